// File: doc/BRIEF.md
# Boundary-Scan Chain for a Bidirectional Pin Bank

This block is the boundary-scan data register that sits between a bank of bidirectional I/O pins, a few input-only pins, and the core logic. It has one cell for each input pin and each I/O pin, and one output-enable cell for each group of I/O pins. Each cell has a capture/shift stage and an update latch. The scan shift path runs from `tdi` to `tdo`. An external TAP controller supplies the capture, shift and update strobes. An external instruction decoder supplies the select and mode signals.

Three modes are available. In normal mode, pins and core are wired straight through, whatever the chain holds. In test mode, the update latches take over: they drive the core's inputs and the pin drivers, and the output-enable latches set the direction of each pin group. Modified test mode drives the core from the latches in the same way, but turns off every pin driver. The bits captured into the chain depend on the mode and on the direction of each pin. This lets the same chain sample a live system or observe the pins during an external test.

Top module: `bscan_bidir_chain`

## Requirements
- R1: The chain is `GROUPS + GROUPS*PINS_PER_GROUP + INPUTS` bits long (44 by default).
  - Bits `[INPUTS-1:0]` are the input-only cells.
  - The next `GROUPS*PINS_PER_GROUP` bits are the I/O cells, with I/O pin k at bit `INPUTS+k`.
  - The top `GROUPS` bits are the output-enable cells, with group g at bit `INPUTS+NIO+g`. By default these are bits 43 to 40.
  - I/O pin k belongs to group `k/PINS_PER_GROUP`.
  - On each `shift_dr` edge, `tdi` enters the top bit, every other bit moves one place down, and `tdo` shows bit 0.
- R2: Capture in normal mode (`mode` 00 or 11):
  - Input cells load `pin_in`.
  - I/O cells whose group has `core_oe`=1 load `core_io_out`.
  - I/O cells whose group has `core_oe`=0 load `pin_io_in`.
- R3: Capture in test mode (`mode`=01) or modified test mode (`mode`=10): input cells load `pin_in`, and every I/O cell loads `pin_io_in`.
- R4: On capture, each output-enable cell loads the enable currently driven on `pin_oe` for its group.
- R5: The update latches load the capture/shift stage only on an `update_dr` edge. Capturing and shifting leave every latched output unchanged.
- R6: While `sel_bsr` is 0, the capture, shift and update strobes have no effect: `tdo` and all latched outputs stay as they were.
- R7: Reset (`rst_n`=0) clears every cell to 0. In test mode this gives `pin_oe`=0, `pin_io_out`=0 and `core_in`=0.
- R8: In normal mode (`mode` 00 or 11), whatever the chain holds:
  - `pin_io_out` equals `core_io_out` and `pin_oe` equals `core_oe`.
  - `core_in` equals `pin_in` and `core_io_in` equals `pin_io_in`.
- R9: In test mode (01), the latches drive the outputs directly:
  - `pin_oe` comes from the output-enable latches (1 = output).
  - `pin_io_out` comes from the I/O latches.
  - `core_in` comes from the input latches.
- R10: In test mode, `core_io_in` depends on each group's output-enable latch. A group with its latch at 0 passes `pin_io_in` to the core. A group with its latch at 1 passes its I/O latch values.
- R11: In modified test mode (10):
  - `pin_oe` is all 0.
  - `core_in` comes from the input latches.
  - `core_io_in` equals `pin_io_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Active-low reset for the chain |
| sel_bsr | input | 1 | This chain is selected in the scan path |
| capture_dr | input | 1 | Capture strobe |
| shift_dr | input | 1 | Shift strobe |
| update_dr | input | 1 | Update strobe |
| mode | input | 2 | 00/11 normal, 01 test, 10 modified test |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (bit 0 of the chain) |
| pin_in | input | INPUTS | Input-only pin levels |
| core_in | output | INPUTS | Values presented to the core for the input pins |
| pin_io_in | input | GROUPS*PINS_PER_GROUP | I/O pin levels seen at the pads |
| pin_io_out | output | GROUPS*PINS_PER_GROUP | I/O pin drive values |
| pin_oe | output | GROUPS | Per-group pin driver enable, 1 = drive |
| core_io_out | input | GROUPS*PINS_PER_GROUP | Core output data for the I/O pins |
| core_oe | input | GROUPS | Core output enable per group |
| core_io_in | output | GROUPS*PINS_PER_GROUP | Values presented to the core for the I/O pins |

## Verification
A fault in the update latches shows up in test mode, on the next falling edge after the update edge, as wrong values on `pin_oe`, `pin_io_out`, `core_in` or `core_io_in`. In normal mode the same fault stays hidden, which is why the bench checks both modes. A fault in the capture/shift stage shows up serially on `tdo`, one bit per shift cycle. A misplaced cell therefore appears at the exact shift count of its bit position. A wrong capture source appears in the first bits shifted out after the capture edge.

// File: rtl/bscan_bidir_chain.sv
module bscan_bidir_chain #(
  parameter int GROUPS         = 4,
  parameter int PINS_PER_GROUP = 9,
  parameter int INPUTS         = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                sel_bsr,
  input  logic                                capture_dr,
  input  logic                                shift_dr,
  input  logic                                update_dr,
  input  logic [1:0]                          mode,
  input  logic                                tdi,
  output logic                                tdo,
  input  logic [INPUTS-1:0]                   pin_in,
  output logic [INPUTS-1:0]                   core_in,
  input  logic [GROUPS*PINS_PER_GROUP-1:0]    pin_io_in,
  output logic [GROUPS*PINS_PER_GROUP-1:0]    pin_io_out,
  output logic [GROUPS-1:0]                   pin_oe,
  input  logic [GROUPS*PINS_PER_GROUP-1:0]    core_io_out,
  input  logic [GROUPS-1:0]                   core_oe,
  output logic [GROUPS*PINS_PER_GROUP-1:0]    core_io_in
);
  localparam int NIO   = GROUPS * PINS_PER_GROUP;
  localparam int LEN   = GROUPS + NIO + INPUTS;
  localparam int IO_LO = INPUTS;
  localparam int OE_LO = INPUTS + NIO;

  logic [LEN-1:0]    sr, upd;
  logic [NIO-1:0]    cap_io, io_lat;
  logic [INPUTS-1:0] in_lat;
  logic [GROUPS-1:0] oe_lat;
  logic              is_test, is_mod, is_norm;

  assign is_test = (mode == 2'b01);
  assign is_mod  = (mode == 2'b10);
  assign is_norm = !is_test && !is_mod;

  assign in_lat = upd[INPUTS-1:0];
  assign io_lat = upd[OE_LO-1:IO_LO];
  assign oe_lat = upd[LEN-1:OE_LO];

  assign pin_oe     = is_norm ? core_oe : (is_test ? oe_lat : '0);
  assign pin_io_out = is_norm ? core_io_out : io_lat;
  assign core_in    = is_norm ? pin_in : in_lat;

  for (genvar k = 0; k < NIO; k++) begin : g_io
    localparam int G = k / PINS_PER_GROUP;
    assign cap_io[k]     = (is_norm && core_oe[G]) ? core_io_out[k] : pin_io_in[k];
    assign core_io_in[k] = (is_test && oe_lat[G]) ? io_lat[k] : pin_io_in[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      upd <= '0;
    end else if (sel_bsr) begin
      if (capture_dr)    sr <= {pin_oe, cap_io, pin_in};
      else if (shift_dr) sr <= {tdi, sr[LEN-1:1]};
      if (update_dr)     upd <= sr;
    end
  end

  assign tdo = sr[0];

  a_r1_shift_path: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_bsr && shift_dr && !capture_dr) |=>
      (sr[LEN-2:0] == $past(sr[LEN-1:1]) && sr[LEN-1] == $past(tdi)));

  a_r3_capture_inputs: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_bsr && capture_dr && !is_norm) |=> sr[INPUTS-1:0] == $past(pin_in));

  a_r5_update_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_bsr && update_dr) |=> $stable(upd));

  a_r5_update_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_bsr && update_dr) |=> upd == $past(sr));

  a_r6_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_bsr |=> $stable(sr));
endmodule

// File: tb/tb_bscan_bidir_chain.sv
module tb_bscan_bidir_chain;
  localparam int G = 4, PG = 9, NI = 4;
  localparam int NIO = G * PG;
  localparam int L = G + NIO + NI;

  logic clk = 0, rst_n = 0, sel_bsr = 0, capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic [1:0] mode = 2'b01;
  logic tdo;
  logic [NI-1:0] pin_in = '0, core_in;
  logic [NIO-1:0] pin_io_in = '0, pin_io_out, core_io_out = '0, core_io_in;
  logic [G-1:0] pin_oe, core_oe = '0;

  int total = 0, bad = 0;
  bit done = 0;
  bit exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  bscan_bidir_chain #(.GROUPS(G), .PINS_PER_GROUP(PG), .INPUTS(NI)) dut (
    .clk(clk), .rst_n(rst_n), .sel_bsr(sel_bsr), .capture_dr(capture_dr),
    .shift_dr(shift_dr), .update_dr(update_dr), .mode(mode), .tdi(tdi), .tdo(tdo),
    .pin_in(pin_in), .core_in(core_in), .pin_io_in(pin_io_in), .pin_io_out(pin_io_out),
    .pin_oe(pin_oe), .core_io_out(core_io_out), .core_oe(core_oe), .core_io_in(core_io_in));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NIO-1:0] gmask(input logic [G-1:0] oe);
    for (int k = 0; k < NIO; k++) gmask[k] = oe[k / PG];
  endfunction

  initial begin
    forever begin
      @(posedge clk); #5;
      if (exp_q.size() > 0) begin
        bit e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(tdo === e, t, {63'b0, tdo}, {63'b0, e});
      end
    end
  end

  task automatic push(input bit e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic scan(input logic [L-1:0] cap, input logic [L-1:0] v, input string t, input bit do_upd);
    @(negedge clk); sel_bsr = 1; capture_dr = 1; push(cap[0], t);
    for (int j = 1; j <= L; j++) begin
      @(negedge clk); capture_dr = 0; shift_dr = 1; tdi = v[j-1];
      if (j < L) push(cap[j], t); else push(v[0], "R1");
    end
    @(negedge clk); shift_dr = 0; update_dr = do_upd;
    @(negedge clk); update_dr = 0;
    wait (exp_q.size() == 0);
  endtask

  task automatic check_test_outputs(input logic [L-1:0] v, input string t);
    logic [NIO-1:0] io, m;
    io = v[NI+NIO-1:NI];
    m  = gmask(v[L-1:NI+NIO]);
    chk(pin_oe === v[L-1:NI+NIO], t, pin_oe, v[L-1:NI+NIO]);
    chk(pin_io_out === io, t, pin_io_out, io);
    chk(core_in === v[NI-1:0], t, core_in, v[NI-1:0]);
    chk(core_io_in === ((io & m) | (pin_io_in & ~m)), "R10", core_io_in, (io & m) | (pin_io_in & ~m));
  endtask

  task automatic check_normal(input string t);
    chk(pin_io_out === core_io_out, t, pin_io_out, core_io_out);
    chk(pin_oe === core_oe, t, pin_oe, core_oe);
    chk(core_in === pin_in, t, core_in, pin_in);
    chk(core_io_in === pin_io_in, t, core_io_in, pin_io_in);
  endtask

  localparam logic [L-1:0] V1 = 44'h6A5C3F09E1D;
  localparam logic [L-1:0] V2 = 44'h93C5A7E812B;

  initial begin
    logic [NIO-1:0] m;
    repeat (3) @(negedge clk);
    chk(pin_oe === '0, "R7", pin_oe, 0);
    chk(pin_io_out === '0, "R7", pin_io_out, 0);
    chk(core_in === '0, "R7", core_in, 0);
    rst_n = 1;

    // R8: normal transparency under several patterns, both encodings
    mode = 2'b00; core_io_out = 36'h5A5A5A5A5; core_oe = 4'b1100; pin_in = 4'hA; pin_io_in = 36'h123456789;
    @(negedge clk); check_normal("R8");
    mode = 2'b11; core_io_out = 36'hFEDCBA987; core_oe = 4'b0011; pin_in = 4'h5; pin_io_in = 36'h0F0F0F0F0;
    @(negedge clk); check_normal("R8");

    // R2/R4: sample in normal mode, direction from core_oe
    mode = 2'b00; core_oe = 4'b0101; core_io_out = 36'hC3C3C3C3C; pin_io_in = 36'h9669A55AF; pin_in = 4'h6;
    m = gmask(core_oe);
    scan({core_oe, (core_io_out & m) | (pin_io_in & ~m), pin_in}, V1, "R2", 1);
    check_normal("R8");

    // R9/R10: test mode driven from latches
    mode = 2'b01;
    @(negedge clk); check_test_outputs(V1, "R9");

    // R3/R4: capture from pins in test mode; R5: no update yet
    pin_io_in = 36'h3C3C3C3C3; pin_in = 4'h9;
    scan({V1[L-1:NI+NIO], pin_io_in, pin_in}, V2, "R3", 0);
    check_test_outputs(V1, "R5");
    @(negedge clk); sel_bsr = 1; update_dr = 1;
    @(negedge clk); update_dr = 0;
    check_test_outputs(V2, "R5");

    // R6: strobes ignored while deselected
    sel_bsr = 0;
    @(negedge clk); capture_dr = 1; tdi = 1;
    @(negedge clk); capture_dr = 0; shift_dr = 1;
    @(negedge clk); shift_dr = 0; update_dr = 1;
    @(negedge clk); update_dr = 0;
    chk(tdo === V2[0], "R6", tdo, V2[0]);
    check_test_outputs(V2, "R6");

    // R11: modified test mode
    mode = 2'b10; pin_io_in = 36'hA1B2C3D4E;
    @(negedge clk);
    chk(pin_oe === '0, "R11", pin_oe, 0);
    chk(core_in === V2[NI-1:0], "R11", core_in, V2[NI-1:0]);
    chk(core_io_in === pin_io_in, "R11", core_io_in, pin_io_in);
    chk(pin_io_out === V2[NI+NIO-1:NI], "R11", pin_io_out, V2[NI+NIO-1:NI]);

    // R3/R4: capture in modified test mode, enables captured as 0
    pin_in = 4'h3;
    scan({4'b0000, pin_io_in, pin_in}, V1, "R4", 1);
    mode = 2'b01;
    @(negedge clk); check_test_outputs(V1, "R9");

    // R7: reset clears latches
    rst_n = 0;
    @(negedge clk);
    chk(pin_oe === '0, "R7", pin_oe, 0);
    chk(core_in === '0, "R7", core_in, 0);
    chk(tdo === 1'b0, "R7", tdo, 0);
    rst_n = 1;

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule